// File: doc/BRIEF.md
# Pipelined Bitonic Packet Sorter

This block takes one slot of N packets per transfer and reorders them by destination address. Each lane carries an active flag, a destination and a payload. It is built to sit in front of a self-routing banyan fabric. That fabric needs the requests of one slot to be concentrated at the low-numbered lanes and to be monotonic in destination, and this block provides both. The sort key of each lane is the inverted active flag placed above the destination bits. As a result, every idle lane counts as larger than every live packet and settles below them. The payload and the active flag move with the key through every exchange.

The network is built from 2x2 compare-exchange cells only. Their count and direction are fixed by the standard bitonic merge recursion. Pairs are sorted first, then merged into sorted runs of four, and so on up to N. Each merge of size k is a half-cleaner followed by smaller half-cleaners, and takes log2(k) cell columns. Every column is registered. The latency is therefore L(L+1)/2 cycles for L = log2(N), which is 6 cycles for N = 8.

Both slot interfaces use valid/ready. A slot is accepted on a clock edge where `in_valid` and `in_ready` are both high. It is delivered on an edge where `out_valid` and `out_ready` are both high. The whole pipeline advances together. `in_ready` is high whenever the last column is empty or `out_ready` is high, so it depends combinationally on `out_ready`. A slot presented on the output is held unchanged until it is taken. Resolving equal destinations and routing through the fabric are left to later stages.

Top module: `bsn_sorter`

## Requirements
- R1: In every delivered slot, the active lanes occupy lanes 0 to c-1, where c is the number of active input lanes, and all higher lanes are inactive.
- R2: Delivered lanes are in non-decreasing order of the key {~active, dest}, with lane 0 holding the smallest key. Active lanes are therefore in ascending destination order.
- R3: The delivered slot holds exactly the input (active, dest, payload) triples, as a multiset. Each payload stays attached to its own destination and active flag.
- R4: Active packets that share a destination are all delivered. None is dropped or merged.
- R5: With `out_ready` held high, a slot accepted on clock edge t is presented with `out_valid` high after edge t+L(L+1)/2-1, which is edge t+5 for N = 8.
- R6: While `out_valid` is high and `out_ready` is low, the outputs stay stable, `out_valid` stays high and `in_ready` is low.
- R7: With `out_ready` high, one slot is accepted per cycle, and slots are delivered in consecutive cycles in the order they were accepted.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: A slot with no active lane is delivered with all active flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input slot present |
| in_ready | output | 1 | Sorter can take a slot this cycle |
| in_active | input | N | Per-lane active flag |
| in_dest | input | N*DW | Per-lane destination, lane i at bits [i*DW +: DW] |
| in_payload | input | N*PW | Per-lane payload, lane i at bits [i*PW +: PW] |
| out_valid | output | 1 | Sorted slot present |
| out_ready | input | 1 | Consumer takes the slot this cycle |
| out_active | output | N | Sorted active flags |
| out_dest | output | N*DW | Sorted destinations |
| out_payload | output | N*PW | Payloads in sorted order |

## Verification
The bench builds the sorter with N = 8, DW = 4 and PW = 8. This gives three merge levels and six registered columns. It exercises both ascending and descending cells, and key collisions are frequent among only 16 destinations. The small destination space makes duplicate destinations and mixed idle/live slots easy to produce. The six-deep pipeline is short enough that stalls can be applied while it is full or partly full.

// File: rtl/bsn_pkg.sv
package bsn_pkg;
  // Number of registered compare columns for a full bitonic sort of 2**lg lanes.
  function automatic int stage_count(input int lg);
    return lg * (lg + 1) / 2;
  endfunction

  // Column index of sub-step q inside merge level p (p counted from 1).
  function automatic int stage_index(input int p, input int q);
    return p * (p - 1) / 2 + q;
  endfunction
endpackage

// File: rtl/bsn_cmp_xchg.sv
module bsn_cmp_xchg #(
  parameter int KW     = 5,
  parameter int PW     = 8,
  parameter bit ASCEND = 1'b1
) (
  input  logic [KW-1:0] a_key,
  input  logic [PW-1:0] a_pay,
  input  logic [KW-1:0] b_key,
  input  logic [PW-1:0] b_pay,
  output logic [KW-1:0] x_key,
  output logic [PW-1:0] x_pay,
  output logic [KW-1:0] y_key,
  output logic [PW-1:0] y_pay
);
  logic swap;

  // Equal keys never swap, so ties leave the pair in place.
  always_comb begin
    if (ASCEND) swap = (a_key > b_key);
    else        swap = (a_key < b_key);
  end

  always_comb begin
    if (swap) begin
      x_key = b_key; x_pay = b_pay;
      y_key = a_key; y_pay = a_pay;
    end else begin
      x_key = a_key; x_pay = a_pay;
      y_key = b_key; y_pay = b_pay;
    end
  end
endmodule

// File: rtl/bsn_stage.sv
module bsn_stage #(
  parameter int N     = 8,
  parameter int KW    = 5,
  parameter int PW    = 8,
  parameter int SPAN  = 1,
  parameter int BLOCK = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            d_v,
  input  logic [N*KW-1:0] d_key,
  input  logic [N*PW-1:0] d_pay,
  output logic            q_v,
  output logic [N*KW-1:0] q_key,
  output logic [N*PW-1:0] q_pay
);
  logic [KW-1:0] nk [N];
  logic [PW-1:0] np [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    if ((i & SPAN) == 0) begin : g_pair
      bsn_cmp_xchg #(
        .KW(KW), .PW(PW), .ASCEND((i & BLOCK) == 0)
      ) u_cx (
        .a_key(d_key[i*KW +: KW]),        .a_pay(d_pay[i*PW +: PW]),
        .b_key(d_key[(i+SPAN)*KW +: KW]), .b_pay(d_pay[(i+SPAN)*PW +: PW]),
        .x_key(nk[i]),                    .x_pay(np[i]),
        .y_key(nk[i+SPAN]),               .y_pay(np[i+SPAN])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_v <= 1'b0;
    else if (adv) q_v <= d_v;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int i = 0; i < N; i++) begin
        q_key[i*KW +: KW] <= nk[i];
        q_pay[i*PW +: PW] <= np[i];
      end
    end
  end

  // Count of live lanes (key MSB low means active).
  function automatic int live_count(input logic [N*KW-1:0] k);
    int c;
    c = 0;
    for (int i = 0; i < N; i++) if (!k[i*KW + KW - 1]) c++;
    return c;
  endfunction

  assert_live_conserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && d_v) |=> (q_v && live_count(q_key) == $past(live_count(d_key))));
endmodule

// File: rtl/bsn_sorter.sv
module bsn_sorter #(
  parameter int N  = 8,
  parameter int DW = 4,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [N-1:0]    in_active,
  input  logic [N*DW-1:0] in_dest,
  input  logic [N*PW-1:0] in_payload,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [N-1:0]    out_active,
  output logic [N*DW-1:0] out_dest,
  output logic [N*PW-1:0] out_payload
);
  import bsn_pkg::*;

  localparam int LG  = $clog2(N);
  localparam int KW  = DW + 1;
  localparam int NST = stage_count(LG);

  logic [N*KW-1:0] sk [NST+1];
  logic [N*PW-1:0] sp [NST+1];
  logic            sv [NST+1];
  logic            adv;

  assign adv      = !sv[NST] || out_ready;
  assign in_ready = adv;

  for (genvar i = 0; i < N; i++) begin : g_key
    assign sk[0][i*KW +: KW] = {~in_active[i], in_dest[i*DW +: DW]};
  end
  assign sp[0] = in_payload;
  assign sv[0] = in_valid;

  for (genvar p = 1; p <= LG; p++) begin : g_level
    for (genvar q = 0; q < p; q++) begin : g_step
      localparam int S = stage_index(p, q);
      bsn_stage #(
        .N(N), .KW(KW), .PW(PW),
        .SPAN(1 << (p - 1 - q)), .BLOCK(1 << p)
      ) u_stage (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .d_v(sv[S]),   .d_key(sk[S]),   .d_pay(sp[S]),
        .q_v(sv[S+1]), .q_key(sk[S+1]), .q_pay(sp[S+1])
      );
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign out_active[i]          = ~sk[NST][i*KW + KW - 1];
    assign out_dest[i*DW +: DW]   = sk[NST][i*KW +: DW];
  end
  assign out_payload = sp[NST];
  assign out_valid   = sv[NST];

  for (genvar i = 0; i + 1 < N; i++) begin : g_chk
    assert_key_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ({~out_active[i], out_dest[i*DW +: DW]} <=
                     {~out_active[i+1], out_dest[(i+1)*DW +: DW]}));
    assert_concentrated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_active[i+1]) |-> out_active[i]);
  end

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_active) &&
                                   $stable(out_dest) && $stable(out_payload)));

  assert_stall_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/bsn_sorter_bench.sv
module bsn_sorter_bench;
  localparam int N   = 8;
  localparam int DW  = 4;
  localparam int PW  = 8;
  localparam int LAT = 6;
  localparam int MAXS = 64;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [N-1:0] in_active = '0, out_active;
  logic [N*DW-1:0] in_dest = '0, out_dest;
  logic [N*PW-1:0] in_payload = '0, out_payload;

  bsn_sorter #(.N(N), .DW(DW), .PW(PW)) u_bsn_sorter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_active(in_active), .in_dest(in_dest), .in_payload(in_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_active(out_active),
    .out_dest(out_dest), .out_payload(out_payload));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, wr = 0, rd = 0;
  logic [N-1:0]    s_act [MAXS];
  logic [N*DW-1:0] s_dst [MAXS];
  logic [N*PW-1:0] s_pay [MAXS];
  int              o_cyc [MAXS];
  logic [N-1:0]    last_act;
  logic [N*DW-1:0] last_dst;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input int idx);
    int ek [N];
    int t, c;
    bit ok;
    bit used [N];
    c = 0;
    for (int i = 0; i < N; i++) begin
      ek[i] = {~s_act[idx][i], s_dst[idx][i*DW +: DW]};
      if (s_act[idx][i]) c++;
    end
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0 && ek[j-1] > ek[j]; j--) begin
        t = ek[j]; ek[j] = ek[j-1]; ek[j-1] = t;
      end
    chk(out_active == N'((1 << c) - 1), "R1", "live lanes packed low",
        out_active, (1 << c) - 1);
    ok = 1;
    for (int i = 0; i < N; i++)
      if ({~out_active[i], out_dest[i*DW +: DW]} != ek[i][DW:0]) ok = 0;
    chk(ok, "R2", "key order", out_dest, 0);
    ok = 1;
    for (int i = 0; i < N; i++) used[i] = 0;
    for (int i = 0; i < N; i++) begin
      bit hit;
      hit = 0;
      for (int j = 0; j < N; j++)
        if (!hit && !used[j] && s_act[idx][j] == out_active[i] &&
            s_dst[idx][j*DW +: DW] == out_dest[i*DW +: DW] &&
            s_pay[idx][j*PW +: PW] == out_payload[i*PW +: PW]) begin
          used[j] = 1; hit = 1;
        end
      if (!hit) ok = 0;
    end
    chk(ok, "R3", "packet multiset", out_payload, s_pay[idx]);
  endtask

  // Output monitor: samples after the bench has driven at the falling edge.
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (rd < wr) check_out(rd);
      else chk(0, "R7", "unexpected slot", rd, wr);
      o_cyc[rd] = cyc;
      last_act = out_active;
      last_dst = out_dest;
      rd++;
    end
  end

  task automatic send(input logic [N-1:0] a, input logic [N*DW-1:0] d,
                      input logic [N*PW-1:0] p);
    in_valid = 1; in_active = a; in_dest = d; in_payload = p;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    s_act[wr] = a; s_dst[wr] = d; s_pay[wr] = p; wr++;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && rd < wr; k++) @(negedge clk);
    #3;
    chk(rd == wr, "R7", "all slots delivered", rd, wr);
  endtask

  task automatic t_reset();
    #3;
    chk(out_valid == 0, "R8", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R8", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_latency();
    int t0;
    t0 = cyc;
    send(8'b1011_0110, 32'h3A5F_2C91, 64'h1122_3344_5566_7788);
    for (int k = 0; k < 20; k++) begin
      #3;
      if (out_valid) break;
      @(negedge clk);
    end
    chk(cyc - t0 == LAT, "R5", "latency", cyc - t0, LAT);
    drain();
  endtask

  task automatic t_patterns();
    int first;
    first = wr;
    send(8'hFF, 32'h0123_4567, 64'hA0A1_A2A3_A4A5_A6A7);  // reversed dests
    send(8'hFF, 32'hFEDC_BA98, 64'hB0B1_B2B3_B4B5_B6B7);  // already sorted
    send(8'h00, 32'h1357_9BDF, 64'hC0C1_C2C3_C4C5_C6C7);  // all idle
    send(8'h81, 32'h0F00_00F0, 64'hD0D1_D2D3_D4D5_D6D7);  // sparse live
    send(8'hFF, 32'h5555_5555, 64'hE0E1_E2E3_E4E5_E6E7);  // one destination
    drain();
    chk(last_act == 8'hFF && last_dst == 32'h5555_5555, "R4",
        "shared destination kept", last_dst, 32'h5555_5555);
    for (int k = first + 1; k < wr; k++)
      chk(o_cyc[k] - o_cyc[k-1] == 1, "R7", "back-to-back delivery",
          o_cyc[k] - o_cyc[k-1], 1);
  endtask

  task automatic t_idle_slot();
    send(8'h00, 32'h0000_0000, 64'h0);
    drain();
    chk(last_act == 8'h00, "R9", "idle slot stays idle", last_act, 0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 12; k++)
      send(N'($urandom), N*DW'($urandom), {$urandom, $urandom});
    drain();
  endtask

  task automatic t_backpressure();
    logic [N-1:0] ha;
    logic [N*DW-1:0] hd;
    logic [N*PW-1:0] hp;
    out_ready = 0;
    send(8'h3C, 32'h9182_7364, 64'h0102_0304_0506_0708);
    send(8'hC3, 32'h2222_7777, 64'h1112_1314_1516_1718);
    send(8'h5A, 32'hE1D2_C3B4, 64'h2122_2324_2526_2728);
    for (int k = 0; k < 20; k++) begin
      #3;
      if (out_valid) break;
      @(negedge clk);
    end
    ha = out_active; hd = out_dest; hp = out_payload;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #3;
      chk(out_valid && out_active == ha && out_dest == hd && out_payload == hp,
          "R6", "held under stall", out_dest, hd);
      chk(in_ready == 0, "R6", "in_ready low under stall", in_ready, 0);
    end
    @(negedge clk);
    out_ready = 1;
    drain();
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "WDOG", "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    t_latency();
    @(negedge clk);
    t_patterns();
    @(negedge clk);
    t_idle_slot();
    @(negedge clk);
    t_random();
    @(negedge clk);
    t_backpressure();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule